// File: doc/BRIEF.md
# Four-Way Fixed-Priority Bus Arbiter

This block decides which of several requesters drives a shared bus. Each requester raises its own request line. The arbiter answers with a grant vector in which at most one bit is set. It is a synchronous state machine with one idle state and one owner state per requester. The grant is decoded from the next state and registered, so it moves only on a rising clock edge. Priority is fixed: the lower a requester's index, the higher its priority, and requester 0 beats all others.

A parameter picks how ownership changes hands:
- **Basic policy:** the owner keeps the bus until it drops its request. The arbiter then spends one cycle idle before it grants again.
- **Handoff policy:** the bus passes straight to the best pending requester when the owner lets go.
- **Preemptive policy:** the best requester takes the bus at every edge, so a higher-priority request displaces a lower-priority owner at once.

The number of requesters is a parameter, with four as the default.

Top module: `bus_arbiter_fsm`

## Requirements
- R1: A synchronous active-high reset puts the arbiter in idle. After the first edge with reset high, `gnt_o` is all zero, whatever the requests are.
- R2: At most one bit of `gnt_o` is set at any time. Bit i of `gnt_o` grants requester i, and bit i of `req_i` is requester i's request.
- R3: In idle with `req_i` all zero, `gnt_o` stays all zero at the next edge.
- R4: In idle with any request set, the next edge grants the lowest-indexed set request. For example, 4'b1111 gives 4'b0001, 4'b0110 gives 4'b0010, 4'b1100 gives 4'b0100, and 4'b1000 gives 4'b1000.
- R5: In the basic and handoff policies, an owner whose request stays high keeps its grant, even when lower-indexed requests appear.
- R6: In the basic policy, when the owner's request is low at an edge, `gnt_o` goes to zero for exactly one cycle. The next edge then grants as from idle.
- R7: In the handoff policy, when the owner's request is low at an edge, the same edge grants the lowest-indexed pending request. If there is none, it goes idle.
- R8: In the preemptive policy, every edge grants the lowest-indexed set request. A lower-indexed request takes the bus from the owner at once, and a higher-indexed one never does.
- R9: `gnt_o` is a registered output. A change on `req_i` between edges leaves it unchanged, and the response shows one edge after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_REQ | Request lines, bit i from requester i |
| gnt_o | output | N_REQ | Registered grant lines, at most one set |

## Verification
Two functions can fall in the same cycle:
- the owner releasing the bus, and
- a competing request asking for it.

The bench provokes the overlap in two ways:
- It drops the owner's line and raises, or keeps, another request at the same edge.
- It raises a lower-indexed request while the owner still holds.

All three policy variants see the same stimulus. Each result is judged against its own rule:
- basic shows one idle cycle,
- handoff moves directly to the best pending requester,
- preemption switches owner even while the old owner still asserts.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    // Ownership policy selector
    typedef enum logic [1:0] {
        POL_BASIC   = 2'd0,
        POL_HANDOFF = 2'd1,
        POL_PREEMPT = 2'd2
    } policy_e;

    // Width of an owner index for n requesters
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bus_arb_pick.sv
module bus_arb_pick #(
    parameter int unsigned N_REQ = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [N_REQ-1:0] req,
    output logic             any_req,
    output logic [IDX_W-1:0] win_idx
);
    // Lowest index wins: scan from the top so the last hit sticks
    always_comb begin
        win_idx = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) win_idx = IDX_W'(i);
        end
    end

    assign any_req = |req;

endmodule

// File: rtl/bus_arb_next.sv
module bus_arb_next
    import bus_arb_pkg::*;
#(
    parameter int unsigned N_REQ  = 4,
    parameter int unsigned IDX_W  = 2,
    parameter policy_e     POLICY = POL_BASIC
) (
    input  logic             cur_busy,
    input  logic [IDX_W-1:0] cur_owner,
    input  logic [N_REQ-1:0] req,
    output logic             nxt_busy,
    output logic [IDX_W-1:0] nxt_owner
);
    logic             any_req;
    logic [IDX_W-1:0] win_idx;
    logic [N_REQ-1:0] own_mask;
    logic             hold;

    bus_arb_pick #(.N_REQ(N_REQ), .IDX_W(IDX_W)) pick_i (
        .req     (req),
        .any_req (any_req),
        .win_idx (win_idx)
    );

    always_comb begin
        own_mask = '0;
        own_mask[cur_owner] = 1'b1;
    end

    // Owner is present and still asserting its request
    assign hold = cur_busy & |(req & own_mask);

    generate
        if (POLICY == POL_BASIC) begin : g_basic
            always_comb begin
                if (cur_busy) begin
                    nxt_busy  = hold;
                    nxt_owner = cur_owner;
                end else begin
                    nxt_busy  = any_req;
                    nxt_owner = win_idx;
                end
            end
        end else if (POLICY == POL_HANDOFF) begin : g_handoff
            always_comb begin
                if (hold) begin
                    nxt_busy  = 1'b1;
                    nxt_owner = cur_owner;
                end else begin
                    nxt_busy  = any_req;
                    nxt_owner = win_idx;
                end
            end
        end else begin : g_preempt
            always_comb begin
                if (hold && (win_idx == cur_owner)) begin
                    nxt_busy  = 1'b1;
                    nxt_owner = cur_owner;
                end else begin
                    nxt_busy  = any_req;
                    nxt_owner = win_idx;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bus_arb_gnt.sv
module bus_arb_gnt #(
    parameter int unsigned N_REQ = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nxt_busy,
    input  logic [IDX_W-1:0] nxt_owner,
    output logic [N_REQ-1:0] gnt
);
    // Registered decode of the next state, aligned with the state register
    always_ff @(posedge clk) begin
        if (rst)           gnt <= '0;
        else if (nxt_busy) gnt <= N_REQ'(1) << nxt_owner;
        else               gnt <= '0;
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

endmodule

// File: rtl/bus_arbiter_fsm.sv
module bus_arbiter_fsm
    import bus_arb_pkg::*;
#(
    parameter int unsigned N_REQ  = 4,
    parameter policy_e     POLICY = POL_BASIC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req_i,
    output logic [N_REQ-1:0] gnt_o
);
    localparam int unsigned IDX_W = idx_width(N_REQ);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] owner;
    } arb_state_t;

    arb_state_t state_q, state_d;

    bus_arb_next #(.N_REQ(N_REQ), .IDX_W(IDX_W), .POLICY(POLICY)) next_i (
        .cur_busy  (state_q.busy),
        .cur_owner (state_q.owner),
        .req       (req_i),
        .nxt_busy  (state_d.busy),
        .nxt_owner (state_d.owner)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    bus_arb_gnt #(.N_REQ(N_REQ), .IDX_W(IDX_W)) gnt_i (
        .clk       (clk),
        .rst       (rst),
        .nxt_busy  (state_d.busy),
        .nxt_owner (state_d.owner),
        .gnt       (gnt_o)
    );

    // Checker-side lowest set request bit
    logic [N_REQ-1:0] low_req;
    assign low_req = req_i & (~req_i + N_REQ'(1));

    // R3
    idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0));

    // R4
    idle_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_o == '0 && req_i != '0) |=> (gnt_o == $past(low_req)));

    generate
        if (POLICY != POL_PREEMPT) begin : g_hold_chk
            // R5
            owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
                ((gnt_o & req_i) != '0) |=> (gnt_o == $past(gnt_o)));
        end
        if (POLICY == POL_BASIC) begin : g_basic_chk
            // R6
            release_gap_chk: assert property (@(posedge clk) disable iff (rst)
                (gnt_o != '0 && (gnt_o & req_i) == '0) |=> (gnt_o == '0));
        end
        if (POLICY == POL_HANDOFF) begin : g_handoff_chk
            // R7
            handoff_chk: assert property (@(posedge clk) disable iff (rst)
                (gnt_o != '0 && (gnt_o & req_i) == '0) |=> (gnt_o == $past(low_req)));
        end
        if (POLICY == POL_PREEMPT) begin : g_preempt_chk
            // R8
            preempt_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (gnt_o == $past(low_req)));
        end
    endgenerate

endmodule

// File: tb/bus_arbiter_fsm_tb_top.sv
module bus_arbiter_fsm_tb_top;
    import bus_arb_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = 4'b0000;
    logic [3:0] gnt_b, gnt_h, gnt_p;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_arbiter_fsm #(.N_REQ(4), .POLICY(POL_BASIC)) dut_i (
        .clk(clk), .rst(rst), .req_i(req), .gnt_o(gnt_b));
    bus_arbiter_fsm #(.N_REQ(4), .POLICY(POL_HANDOFF)) dut_hand_i (
        .clk(clk), .rst(rst), .req_i(req), .gnt_o(gnt_h));
    bus_arbiter_fsm #(.N_REQ(4), .POLICY(POL_PREEMPT)) dut_pre_i (
        .clk(clk), .rst(rst), .req_i(req), .gnt_o(gnt_p));

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive, confirm no mid-cycle change, then sample after the edge
    task automatic step(input logic [3:0] r, input logic [3:0] eb,
                        input logic [3:0] eh, input logic [3:0] ep, input string tag);
        logic [3:0] pb, ph, pp;
        pb = gnt_b; ph = gnt_h; pp = gnt_p;
        req = r;
        #1;
        chk("R9 basic between edges", gnt_b, pb);
        chk("R9 handoff between edges", gnt_h, ph);
        chk("R9 preempt between edges", gnt_p, pp);
        @(negedge clk);
        chk({tag, " basic"}, gnt_b, eb);
        chk({tag, " handoff"}, gnt_h, eh);
        chk({tag, " preempt"}, gnt_p, ep);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        req = 4'b1111;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset basic", gnt_b, 4'b0000);
        chk("R1 reset handoff", gnt_h, 4'b0000);
        chk("R1 reset preempt", gnt_p, 4'b0000);
        req = 4'b0000;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_idle();
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R3 idle");
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R3 idle again");
    endtask

    task automatic t_pick();
        step(4'b1111, 4'b0001, 4'b0001, 4'b0001, "R4 all req");
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R4 release");
        step(4'b0110, 4'b0010, 4'b0010, 4'b0010, "R4 pick 1");
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R4 release");
        step(4'b1100, 4'b0100, 4'b0100, 4'b0100, "R4 pick 2");
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R4 release");
        step(4'b1000, 4'b1000, 4'b1000, 4'b1000, "R4 pick 3");
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R4 release");
    endtask

    task automatic t_higher_arrives();
        step(4'b1000, 4'b1000, 4'b1000, 4'b1000, "R4 owner 3");
        step(4'b1001, 4'b1000, 4'b1000, 4'b0001, "R5 R8 higher arrives");
        step(4'b1001, 4'b1000, 4'b1000, 4'b0001, "R5 R8 higher stays");
        step(4'b0001, 4'b0000, 4'b0001, 4'b0001, "R6 R7 owner drops");
        step(4'b0001, 4'b0001, 4'b0001, 4'b0001, "R6 grant after gap");
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R6 R7 release to idle");
    endtask

    task automatic t_lower_arrives();
        step(4'b0010, 4'b0010, 4'b0010, 4'b0010, "R4 owner 1");
        step(4'b0110, 4'b0010, 4'b0010, 4'b0010, "R5 R8 lower waits");
        step(4'b0100, 4'b0000, 4'b0100, 4'b0100, "R6 R7 R8 release");
        step(4'b0100, 4'b0100, 4'b0100, 4'b0100, "R6 after gap");
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R7 none pending");
    endtask

    task automatic t_handoff_best();
        step(4'b0001, 4'b0001, 4'b0001, 4'b0001, "R4 owner 0");
        step(4'b1110, 4'b0000, 4'b0010, 4'b0010, "R7 R8 best pending");
        step(4'b1110, 4'b0010, 4'b0010, 4'b0010, "R6 gap then best");
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R7 release");
    endtask

    task automatic t_reset_busy();
        step(4'b0100, 4'b0100, 4'b0100, 4'b0100, "R4 owner 2");
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset while busy basic", gnt_b, 4'b0000);
        chk("R1 reset while busy handoff", gnt_h, 4'b0000);
        chk("R1 reset while busy preempt", gnt_p, 4'b0000);
        rst = 1'b0;
        step(4'b0100, 4'b0100, 4'b0100, 4'b0100, "R1 R4 regrant after reset");
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R3 final idle");
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_idle();
        t_pick();
        t_higher_arrives();
        t_lower_arrives();
        t_handoff_best();
        t_reset_busy();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule